// File: doc/BRIEF.md
# Conditional Sum Adder

This block is a purely combinational two-operand binary adder for a word of `WIDTH` bits. Each bit pair starts as a one-bit group that offers two ready-made results: one that holds if no carry enters it, and one that holds if a carry does. Neighbouring groups are then merged level by level. In each merge, the low half's two possible carry-outs pick which of the high half's result pairs survives. This continues until one group covers the whole word. Because the select lines are known as soon as the operands are, no carry has to ripple through the bits one at a time.

The forced carry-in is available from the start. The group that holds the least significant bit therefore never needs a second candidate. At every level it carries a single, already-resolved result, and its carry-out selects directly among the upper group's candidates. The final sum and carry-out come from that resolved chain.

When the width is not a power of two, each group is split unevenly. The low part is the largest power of two below the group width, and the high part takes the rest. A 12-bit word therefore splits into 8 and 4 bits, and a 3-bit word into 2 and 1. The number of select levels is the ceiling of log2 of the width, which is 3 for 8 bits.

Top module: `cond_sum_adder`

## Requirements
- R1: At the default width of 8, for every operand pair and both carry-in values, {carry_out, sum} equals op_a + op_b + carry_in.
- R2: At widths that are not powers of two (3 and 12), {carry_out, sum} equals op_a + op_b + carry_in.
- R3: At a width of 1, the block behaves as a full adder: sum is the XOR of the three inputs and carry_out is their majority.
- R4: When op_b is the bitwise complement of op_a and carry_in is 1, sum is all zeros and carry_out is 1. The carry passes through every select level.
- R5: When op_b is the bitwise complement of op_a and carry_in is 0, sum is all ones and carry_out is 0.
- R6: When both operands are zero, sum equals carry_in in bit 0 with all other bits 0, and carry_out is 0.
- R7: When both operands are all ones, carry_out is 1, bit 0 of sum equals carry_in, and all other sum bits are 1.
- R8: When the most significant bit of both operands is 0, carry_out is 0.
- R9: The outputs depend only on the present inputs. They settle without any clock edge, and the same inputs give the same outputs whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand, unsigned binary |
| op_b | input | WIDTH | Second operand, unsigned binary |
| carry_in | input | 1 | Forced carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bound checker tests the arithmetic identity at every input change, at every instantiated width. It also tests the corner patterns: full propagate, full generate, zero operands, and no carry when both top bits are clear. Only the bench's scenarios can show that the identity holds over the full input space at 8 bits and at the 1-bit and 3-bit widths. The same applies to coverage of the uneven 12-bit split under random operands. The bench also checks that results do not depend on the previous input (R9), by returning to earlier operand values after unrelated ones and seeing the same output.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Size of the low part when a group of w bits (w > 1) is split:
    // the largest power of two strictly below w.
    function automatic int split_lo(input int w);
        int p;
        p = 1;
        while (p * 2 < w) begin
            p = p * 2;
        end
        return p;
    endfunction

    // Number of select levels for a word of w bits.
    function automatic int level_count(input int w);
        int n;
        int p;
        n = 0;
        p = 1;
        while (p < w) begin
            p = p * 2;
            n = n + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/csa_bit_pair.sv
// One-bit group: both candidate results for a single bit position.
module csa_bit_pair (
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_if0,
    output logic sum_if1,
    output logic cout_if0,
    output logic cout_if1
);
    logic half;

    assign half     = a_bit ^ b_bit;
    assign sum_if0  = half;
    assign sum_if1  = ~half;
    assign cout_if0 = a_bit & b_bit;
    assign cout_if1 = a_bit | b_bit;
endmodule

// File: rtl/csa_dual_node.sv
// Group of W bits that offers two result sets, one per assumed carry-in.
// Built recursively: low part of split_lo(W) bits, high part of the rest.
module csa_dual_node #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_grp,
    input  logic [W-1:0] b_grp,
    output logic [W-1:0] sum_if0,
    output logic [W-1:0] sum_if1,
    output logic         cout_if0,
    output logic         cout_if1
);
    generate
        if (W == 1) begin : g_leaf
            csa_bit_pair u_pair (
                .a_bit    (a_grp[0]),
                .b_bit    (b_grp[0]),
                .sum_if0  (sum_if0[0]),
                .sum_if1  (sum_if1[0]),
                .cout_if0 (cout_if0),
                .cout_if1 (cout_if1)
            );
        end else begin : g_split
            localparam int LO = csa_pkg::split_lo(W);
            localparam int HI = W - LO;

            logic [LO-1:0] lo_s0, lo_s1;
            logic          lo_c0, lo_c1;
            logic [HI-1:0] hi_s0, hi_s1;
            logic          hi_c0, hi_c1;

            csa_dual_node #(.W(LO)) u_lo (
                .a_grp    (a_grp[LO-1:0]),
                .b_grp    (b_grp[LO-1:0]),
                .sum_if0  (lo_s0),
                .sum_if1  (lo_s1),
                .cout_if0 (lo_c0),
                .cout_if1 (lo_c1)
            );

            csa_dual_node #(.W(HI)) u_hi (
                .a_grp    (a_grp[W-1:LO]),
                .b_grp    (b_grp[W-1:LO]),
                .sum_if0  (hi_s0),
                .sum_if1  (hi_s1),
                .cout_if0 (hi_c0),
                .cout_if1 (hi_c1)
            );

            // The low part's candidate carry becomes internal and picks
            // the matching high-part candidate.
            assign sum_if0  = {(lo_c0 ? hi_s1 : hi_s0), lo_s0};
            assign sum_if1  = {(lo_c1 ? hi_s1 : hi_s0), lo_s1};
            assign cout_if0 = lo_c0 ? hi_c1 : hi_c0;
            assign cout_if1 = lo_c1 ? hi_c1 : hi_c0;
        end
    endgenerate
endmodule

// File: rtl/csa_lsb_node.sv
// Least-significant group: the carry-in is known, so only one result set
// is formed; its carry selects among the high part's two candidates.
module csa_lsb_node #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_grp,
    input  logic [W-1:0] b_grp,
    input  logic         cin,
    output logic [W-1:0] sum_res,
    output logic         cout_res
);
    generate
        if (W == 1) begin : g_leaf
            logic half;
            assign half       = a_grp[0] ^ b_grp[0];
            assign sum_res[0] = half ^ cin;
            assign cout_res   = (a_grp[0] & b_grp[0]) | (cin & half);
        end else begin : g_split
            localparam int LO = csa_pkg::split_lo(W);
            localparam int HI = W - LO;

            logic [LO-1:0] lo_s;
            logic          lo_c;
            logic [HI-1:0] hi_s0, hi_s1;
            logic          hi_c0, hi_c1;

            csa_lsb_node #(.W(LO)) u_lo (
                .a_grp    (a_grp[LO-1:0]),
                .b_grp    (b_grp[LO-1:0]),
                .cin      (cin),
                .sum_res  (lo_s),
                .cout_res (lo_c)
            );

            csa_dual_node #(.W(HI)) u_hi (
                .a_grp    (a_grp[W-1:LO]),
                .b_grp    (b_grp[W-1:LO]),
                .sum_if0  (hi_s0),
                .sum_if1  (hi_s1),
                .cout_if0 (hi_c0),
                .cout_if1 (hi_c1)
            );

            assign sum_res  = {(lo_c ? hi_s1 : hi_s0), lo_s};
            assign cout_res = lo_c ? hi_c1 : hi_c0;
        end
    endgenerate
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    // Depth of the select tree, for reference by integrators.
    localparam int LEVELS = csa_pkg::level_count(WIDTH);

    initial begin
        if (WIDTH < 1) $error("cond_sum_adder: WIDTH must be at least 1");
        if (LEVELS < 0) $error("cond_sum_adder: bad level count");
    end

    csa_lsb_node #(.W(WIDTH)) u_root (
        .a_grp    (op_a),
        .b_grp    (op_b),
        .cin      (carry_in),
        .sum_res  (sum),
        .cout_res (carry_out)
    );
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    logic [WIDTH:0]   model;
    logic [WIDTH-1:0] ones;

    always_comb begin
        ones  = '1;
        model = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            // R1, R2, R3, R9: arithmetic identity at every width, every change
            a_r1_exact_sum: assert ({carry_out, sum} == model)
                else $error("R1 sum mismatch");
            if (op_b == ~op_a && carry_in) begin
                a_r4_full_propagate: assert (sum == '0 && carry_out)
                    else $error("R4 propagate chain");
            end
            if (op_b == ~op_a && !carry_in) begin
                a_r5_ones_no_carry: assert (sum == ones && !carry_out)
                    else $error("R5 complement pair");
            end
            if (op_a == '0 && op_b == '0) begin
                a_r6_zero_operands: assert (sum == {{(WIDTH-1){1'b0}}, carry_in} || WIDTH == 1)
                    else $error("R6 zero operands");
                a_r6_zero_no_carry: assert (!carry_out)
                    else $error("R6 zero carry");
            end
            if (op_a == ones && op_b == ones) begin
                a_r7_all_generate: assert (carry_out && sum[0] == carry_in)
                    else $error("R7 all generate");
            end
            if (!op_a[WIDTH-1] && !op_b[WIDTH-1]) begin
                a_r8_no_top_carry: assert (!carry_out)
                    else $error("R8 top carry");
            end
        end
    end
endmodule

bind cond_sum_adder csa_checker #(.WIDTH(WIDTH)) u_csa_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/cond_sum_adder_test.sv
`timescale 1ns/1ps
module cond_sum_adder_test;
    logic clk;
    logic rst_n;
    int   total;
    int   bad;
    int   cycles;
    logic done;

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [11:0] a12, b12, s12;
    logic        c12, co12;
    logic [2:0]  a3, b3, s3;
    logic        c3, co3;
    logic [0:0]  a1, b1, s1;
    logic        c1, co1;

    cond_sum_adder #(.WIDTH(8))  uut  (.op_a(a8),  .op_b(b8),  .carry_in(c8),  .sum(s8),  .carry_out(co8));
    cond_sum_adder #(.WIDTH(12)) u_w12 (.op_a(a12), .op_b(b12), .carry_in(c12), .sum(s12), .carry_out(co12));
    cond_sum_adder #(.WIDTH(3))  u_w3  (.op_a(a3),  .op_b(b3),  .carry_in(c3),  .sum(s3),  .carry_out(co3));
    cond_sum_adder #(.WIDTH(1))  u_w1  (.op_a(a1),  .op_b(b1),  .carry_in(c1),  .sum(s1),  .carry_out(co1));

    function automatic logic [12:0] ref_add(input logic [11:0] a, input logic [11:0] b,
                                            input logic ci, input int w);
        logic [12:0] t;
        logic [12:0] mask;
        t    = {1'b0, a} + {1'b0, b} + {12'd0, ci};
        mask = (13'd1 << (w + 1)) - 13'd1;
        return t & mask;
    endfunction

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive after the rising edge, sample well before the next one.
    task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic ci);
        @(posedge clk);
        #1 a8 = a; b8 = b; c8 = ci;
        #2;
    endtask

    task automatic apply12(input logic [11:0] a, input logic [11:0] b, input logic ci);
        @(posedge clk);
        #1 a12 = a; b12 = b; c12 = ci;
        #2;
    endtask

    initial begin
        cycles = 0;
        done   = 1'b0;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [12:0] r;
        logic [12:0] first;
        total = 0;
        bad   = 0;
        r = 13'($urandom(32'h5EED_C0DE));
        rst_n = 1'b0;
        a8 = '0; b8 = '0; c8 = 1'b0;
        a12 = '0; b12 = '0; c12 = 1'b0;
        a3 = '0; b3 = '0; c3 = 1'b0;
        a1 = '0; b1 = '0; c1 = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        // Reset state with idle operands: R6
        check("R6 reset idle 8b", {4'd0, co8, s8}, 13'd0);
        check("R6 reset idle 12b", {co12, s12}, 13'd0);
        rst_n = 1'b1;

        // R3: one-bit width is a full adder
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #1 a1 = k[0]; b1 = k[1]; c1 = k[2];
            #2 check("R3 full adder", {11'd0, co1, s1},
                     {11'd0, (k[0] & k[1]) | (k[2] & (k[0] ^ k[1])), k[0] ^ k[1] ^ k[2]});
        end

        // R2: exhaustive at width 3 (uneven split 2 + 1)
        for (int k = 0; k < 128; k++) begin
            @(posedge clk);
            #1 a3 = k[2:0]; b3 = k[5:3]; c3 = k[6];
            #2 check("R2 width 3", {9'd0, co3, s3}, ref_add({9'd0, k[2:0]}, {9'd0, k[5:3]}, k[6], 3));
        end

        // Directed corners at width 8: R4, R5, R6, R7, R8
        apply8(8'hA5, 8'h5A, 1'b1); check("R4 propagate 8b", {4'd0, co8, s8}, 13'h100);
        apply8(8'h3C, 8'hC3, 1'b0); check("R5 complement 8b", {4'd0, co8, s8}, 13'h0FF);
        apply8(8'h00, 8'h00, 1'b1); check("R6 zero cin1 8b", {4'd0, co8, s8}, 13'h001);
        apply8(8'hFF, 8'hFF, 1'b1); check("R7 generate 8b", {4'd0, co8, s8}, 13'h1FF);
        apply8(8'hFF, 8'hFF, 1'b0); check("R7 generate cin0 8b", {4'd0, co8, s8}, 13'h1FE);
        apply8(8'h7F, 8'h7F, 1'b1); check("R8 no top carry 8b", {4'd0, co8, s8}, 13'h0FF);

        // R1: exhaustive at width 8
        for (int k = 0; k < 131072; k++) begin
            apply8(k[7:0], k[15:8], k[16]);
            check("R1 width 8", {4'd0, co8, s8}, ref_add({4'd0, k[7:0]}, {4'd0, k[15:8]}, k[16], 8));
        end

        // R9: same inputs after unrelated ones give the same result
        apply8(8'h81, 8'h7F, 1'b0);
        first = {4'd0, co8, s8};
        apply8(8'hFF, 8'h01, 1'b1);
        apply8(8'h81, 8'h7F, 1'b0);
        check("R9 history independent", {4'd0, co8, s8}, first);
        check("R9 value", first, 13'h100);

        // Directed corners at width 12: R4, R5, R7, R8
        apply12(12'h9A6, 12'h659, 1'b1); check("R4 propagate 12b", {co12, s12}, 13'h1000);
        apply12(12'h0F0, 12'hF0F, 1'b0); check("R5 complement 12b", {co12, s12}, 13'h0FFF);
        apply12(12'hFFF, 12'hFFF, 1'b0); check("R7 generate 12b", {co12, s12}, 13'h1FFE);
        apply12(12'h7FF, 12'h7FF, 1'b1); check("R8 no top carry 12b", {co12, s12}, 13'h0FFF);
        apply12(12'h0FF, 12'h001, 1'b0); check("R2 carry across 8|4 split", {co12, s12}, 13'h0100);

        // R2: random at width 12
        for (int k = 0; k < 4000; k++) begin
            logic [11:0] ra, rb;
            logic        rc;
            ra = 12'($urandom);
            rb = 12'($urandom);
            rc = 1'($urandom);
            apply12(ra, rb, rc);
            check("R2 width 12 random", {co12, s12}, ref_add(ra, rb, rc, 12));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule